// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block drives a single display-backlight dimming pin with a pulse-width waveform. The waveform has three timing values: a clock prescaler, a period count and a high-width count. Software programs them through a small word-addressed register port that takes a select, a write flag, an address and write data, and returns read data. Writes land in shadow copies of the timing fields. A commit request copies all of them into the active set together. The copy happens at the next period boundary, so a running waveform never shows a mix of old and new values inside one period. If the generator is stopped, the copy happens at once.

A bypass mode turns the shadow copies off as a stage. In this mode, shadow writes reach the active set one cycle later and need no commit. An enable bit starts and stops the waveform. While stopped, the pin is held low and both counters sit at zero. Each new run therefore begins with a full period.

Top module: `blpwm_top`

## Requirements
- R1: After reset the pin is low, and reads of all four register words (word 0 control, 1 load, 2 divider, 3 timing) return zero.
- R2: With prescaler D, period P and high width H, each output period lasts (D+1)*(P+1) clock cycles. The pin is high for the first (D+1)*H of them.
- R3: The prescaler D is the 10-bit field at bits [25:16] of word 2, and its full value 0x3FF is honoured: D=0x3FF, P=1, H=1 gives 1024 cycles high and 1024 low.
- R4: The period P is the 12-bit field at bits [11:0] of word 3, and the high width H is the 13-bit field at bits [28:16] of word 3.
- R5: Without bypass, writes to words 2 and 3 do not change the waveform until a commit.
- R6: Writing word 1 with bit 0 set requests a commit. While running, the current period completes with the old values, and the new values take effect from the next period.
- R7: A commit requested while the generator is stopped is applied at once, so the first period after enabling uses the new values.
- R8: With bypass (word 0 bit 1) set, writes to words 2 and 3 take effect without any commit.
- R9: Word 0 bit 0 is the enable. Clearing it drives the pin low within two cycles and keeps it low. Setting it again starts a complete period from zero.
- R10: When H is at least P+1, the pin stays high for the whole period. When H is 0, the pin stays low.
- R11: Reads return the shadow contents. Bits that hold no field read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pwm_o | output | 1 | Registered backlight PWM output |

## Verification
The assertions assume that each register access lasts exactly one cycle with the select high. They also assume that software changes timing values either through commits or, in bypass, while it accepts a wrap in mid-period. For that reason no property ties the pin to the active values right after bypass has been left. The stimulus keeps to these assumptions: it issues one access at a time, with the select low in between. It loads new values into a running generator only through commits, and it leaves bypass only by stopping the generator. Waveform checks compare whole periods, measured from one rising edge to the next, against values computed from the programmed fields.

// File: rtl/blpwm_pkg.sv
package blpwm_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int DIV_W   = 10;
  localparam int PER_W   = 12;
  localparam int HI_W    = 13;
  localparam int DIV_LSB = 16;
  localparam int PER_LSB = 0;
  localparam int HI_LSB  = 16;
  localparam int EN_BIT  = 0;
  localparam int BYP_BIT = 1;
  localparam int GO_BIT  = 0;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_LOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;
  localparam logic [ADDR_W-1:0] A_TIME = 2'd3;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
    logic [HI_W-1:0]  hi;
  } tcfg_t;
endpackage

// File: rtl/blpwm_regfile.sv
module blpwm_regfile
  import blpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              bypass,
  output logic              commit,
  output tcfg_t             shadow
);
  logic              go_bit;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[DATA_W-1:HI_LSB+HI_W], wdata[HI_LSB-1:PER_LSB+PER_W]};

  // Commit request: a write to the load word with its go bit set.
  assign commit = sel && wr && (addr == A_LOAD) && wdata[GO_BIT];

  always_comb begin
    rd_next = '0;
    case (addr)
      A_CTRL: begin
        rd_next[EN_BIT]  = en;
        rd_next[BYP_BIT] = bypass;
      end
      A_LOAD: rd_next[GO_BIT] = go_bit;
      A_DIV:  rd_next[DIV_LSB +: DIV_W] = shadow.div;
      default: begin
        rd_next[PER_LSB +: PER_W] = shadow.per;
        rd_next[HI_LSB +: HI_W]   = shadow.hi;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      bypass <= 1'b0;
      go_bit <= 1'b0;
      shadow <= '0;
      rdata  <= '0;
    end else begin
      if (sel && wr) begin
        case (addr)
          A_CTRL: begin
            en     <= wdata[EN_BIT];
            bypass <= wdata[BYP_BIT];
          end
          A_LOAD: go_bit <= wdata[GO_BIT];
          A_DIV:  shadow.div <= wdata[DIV_LSB +: DIV_W];
          default: begin
            shadow.per <= wdata[PER_LSB +: PER_W];
            shadow.hi  <= wdata[HI_LSB +: HI_W];
          end
        endcase
      end
      if (sel && !wr) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/blpwm_loader.sv
module blpwm_loader
  import blpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  bypass,
  input  logic  commit,
  input  logic  wrap,
  input  tcfg_t shadow,
  output tcfg_t active,
  output logic  pend
);
  logic want;
  logic slot;

  assign want = commit || pend;
  // A load slot is any cycle in which the waveform is stopped or a period ends.
  assign slot = !en || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      pend   <= 1'b0;
    end else if (bypass) begin
      active <= shadow;
      pend   <= 1'b0;
    end else if (want && slot) begin
      active <= shadow;
      pend   <= 1'b0;
    end else if (commit) begin
      pend   <= 1'b1;
    end
  end
endmodule

// File: rtl/blpwm_prescaler.sv
module blpwm_prescaler #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  // >= keeps the count bounded if the limit shrinks under it.
  assign tick = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/blpwm_wavegen.sv
module blpwm_wavegen #(
  parameter int PW = 12,
  parameter int HW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [PW-1:0] last,
  input  logic [HW-1:0] high,
  output logic          wrap,
  output logic [PW-1:0] pos,
  output logic          pwm_o
);
  localparam int CW = (PW + 1 > HW) ? PW + 1 : HW;

  logic [CW-1:0] pos_x;
  logic [CW-1:0] high_x;

  assign pos_x  = CW'(pos);
  assign high_x = CW'(high);
  assign wrap   = tick && (pos >= last);

  always_ff @(posedge clk) begin
    if (rst || !run)  pos <= '0;
    else if (wrap)    pos <= '0;
    else if (tick)    pos <= pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= run && (pos_x < high_x);
  end
endmodule

// File: rtl/blpwm_top.sv
module blpwm_top
  import blpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_o
);
  logic             en;
  logic             bypass;
  logic             commit;
  logic             wrap;
  logic             tick;
  logic             pend;
  logic [PER_W-1:0] pos;
  tcfg_t            shadow;
  tcfg_t            act;

  blpwm_regfile u_regs (
    .clk    (clk),
    .rst    (rst),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .en     (en),
    .bypass (bypass),
    .commit (commit),
    .shadow (shadow)
  );

  blpwm_loader u_load (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .bypass (bypass),
    .commit (commit),
    .wrap   (wrap),
    .shadow (shadow),
    .active (act),
    .pend   (pend)
  );

  blpwm_prescaler #(.W(DIV_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .run   (en),
    .limit (act.div),
    .tick  (tick)
  );

  blpwm_wavegen #(.PW(PER_W), .HW(HI_W)) u_wave (
    .clk   (clk),
    .rst   (rst),
    .run   (en),
    .tick  (tick),
    .last  (act.per),
    .high  (act.hi),
    .wrap  (wrap),
    .pos   (pos),
    .pwm_o (pwm_o)
  );
endmodule

// File: rtl/blpwm_checker.sv
module blpwm_checker
  import blpwm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              bypass,
  input logic              commit,
  input logic              wrap,
  input logic              pend,
  input logic [PER_W-1:0]  pos,
  input tcfg_t             shadow,
  input tcfg_t             act,
  input logic [DATA_W-1:0] rdata,
  input logic              pwm_o
);
  a_r9_off_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_o);

  a_r9_counters_held: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pos == '0));

  a_r6_active_steady: assert property (@(posedge clk) disable iff (rst)
    (en && !bypass && !wrap) |=> $stable(act));

  a_r6_request_waits: assert property (@(posedge clk) disable iff (rst)
    (commit && en && !bypass && !wrap) |=> pend);

  a_r8_bypass_follow: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (act == $past(shadow)));

  a_r10_zero_width: assert property (@(posedge clk) disable iff (rst)
    (en && act.hi == '0) |=> !pwm_o);

  // R11: no register uses these bit ranges, so they always read zero.
  always @(posedge clk) begin
    if (!rst) begin
      a_r11_unused_zero: assert (rdata[DATA_W-1:HI_LSB+HI_W] == '0 &&
                                 rdata[HI_LSB-1:PER_LSB+PER_W] == '0);
    end
  end
endmodule

bind blpwm_top blpwm_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .bypass (bypass),
  .commit (commit),
  .wrap   (wrap),
  .pend   (pend),
  .pos    (pos),
  .shadow (shadow),
  .act    (act),
  .rdata  (bus_rdata),
  .pwm_o  (pwm_o)
);

// File: tb/blpwm_top_test.sv
`timescale 1ns/100ps
module blpwm_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_restart = 1'b0;

  typedef struct { int hi; int lo; string tag; } exp_t;
  exp_t exp_q[$];
  event period_start;

  always #2.5 clk = ~clk;

  blpwm_top uut (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwm_o(pwm)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    sel = 1'b1; wr = 1'b0; addr = a;
    @(posedge clk); #1;
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic commit();
    bus_write(2'd1, 32'h1);
    bus_write(2'd1, 32'h0);
  endtask

  task automatic set_timing(input int d, input int p, input int h);
    bus_write(2'd2, 32'(d) << 16);
    bus_write(2'd3, (32'(h) << 16) | 32'(p));
  endtask

  task automatic restart_mon();
    @(posedge clk); #1 mon_restart = 1'b1;
    @(posedge clk); #1 mon_restart = 1'b0;
  endtask

  task automatic push(input int hi, input int lo, input string tag);
    exp_t e;
    e.hi = hi; e.lo = lo; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm) h++;
    end
  endtask

  // Monitor: measures each full period between rising edges and scores it.
  int  m_hi = 0, m_lo = 0;
  bit  m_have = 1'b0, m_prev = 1'b0;
  always @(negedge clk) begin
    if (rst || mon_restart) begin
      m_hi = 0; m_lo = 0; m_have = 1'b0; m_prev = 1'b0;
    end else begin
      if (pwm && !m_prev) begin
        if (m_have && exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(m_hi == e.hi, {e.tag, " high cycles"}, m_hi, e.hi);
          check(m_lo == e.lo, {e.tag, " low cycles"}, m_lo, e.lo);
        end
        m_have = 1'b1; m_hi = 1; m_lo = 0;
        -> period_start;
      end else if (pwm) begin
        m_hi++;
      end else begin
        m_lo++;
      end
      m_prev = pwm;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] rd;
    int h;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    check(pwm == 1'b0, "R1 pin low", int'(pwm), 0);
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), rd);
      check(rd == 32'h0, "R1 register zero", int'(rd), 0);
    end

    // R11 / R3 / R4: field placement and unused bits
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, rd);
    check(rd == 32'h03FF_0000, "R3 R11 divider readback", int'(rd), 32'h03FF_0000);
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd3, rd);
    check(rd == 32'h1FFF_0FFF, "R4 R11 timing readback", int'(rd), 32'h1FFF_0FFF);
    bus_write(2'd0, 32'hFFFF_FFF8);
    bus_read(2'd0, rd);
    check(rd == 32'h0, "R11 control unused bits", int'(rd), 0);

    // R5: shadow writes alone do nothing
    set_timing(0, 9, 3);
    bus_write(2'd0, 32'h1);
    count_high(200, h);
    check(h == 0, "R5 no commit no change", h, 0);

    // R7 + R2: commit while stopped applies at once
    bus_write(2'd0, 32'h0);
    commit();
    restart_mon();
    push(3, 7, "R7 first period");
    push(3, 7, "R2 pattern A");
    bus_write(2'd0, 32'h1);
    repeat (3) @(period_start);

    // R6: commit mid-period waits for the boundary
    bus_write(2'd0, 32'h0);
    set_timing(0, 59, 30);
    commit();
    restart_mon();
    bus_write(2'd0, 32'h1);
    @(period_start);
    push(30, 30, "R6 old period intact");
    push(10, 30, "R6 new period");
    set_timing(1, 19, 5);
    commit();
    repeat (2) @(period_start);

    // R3: largest prescaler
    bus_write(2'd0, 32'h0);
    set_timing(10'h3FF, 1, 1);
    commit();
    restart_mon();
    push(1024, 1024, "R3 max divider");
    bus_write(2'd0, 32'h1);
    repeat (2) @(period_start);

    // R10: saturated and zero widths
    bus_write(2'd0, 32'h0);
    set_timing(0, 9, 10);
    commit();
    bus_write(2'd0, 32'h1);
    repeat (20) @(negedge clk);
    count_high(100, h);
    check(h == 100, "R10 width equals period", h, 100);
    set_timing(0, 9, 12);
    commit();
    repeat (30) @(negedge clk);
    count_high(100, h);
    check(h == 100, "R10 width above period", h, 100);
    set_timing(0, 9, 0);
    commit();
    repeat (30) @(negedge clk);
    count_high(100, h);
    check(h == 0, "R10 zero width", h, 0);

    // R8: bypass takes writes directly
    bus_write(2'd0, 32'h3);
    set_timing(0, 7, 2);
    repeat (2) @(period_start);
    push(2, 6, "R8 bypass");
    @(period_start);

    // R9: stop and restart
    bus_write(2'd0, 32'h0);
    repeat (2) @(negedge clk);
    check(pwm == 1'b0, "R9 low after stop", int'(pwm), 0);
    count_high(50, h);
    check(h == 0, "R9 stays low", h, 0);
    set_timing(2, 4, 2);
    commit();
    restart_mon();
    push(6, 9, "R9 full first period");
    push(6, 9, "R2 pattern B");
    bus_write(2'd0, 32'h1);
    repeat (3) @(period_start);

    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule